// File: doc/BRIEF.md
# Vector Length Prefix Control Unit

This unit sits in the decode stage of a processor that takes 64-bit prefixed instructions. It reads a 12-bit vector-length control field from bits 59:48 of the instruction and decides how the architectural vector length (VL) and its ceiling (MAXVL) change. It also decides whether the new VL should be copied into a scalar register. The field has four parts:

- a mode bit (bit 11);
- a five-bit scalar destination index (bits 10:6);
- a five-bit immediate, which doubles as a scalar source index (bits 5:1);
- a source-select flag (bit 0).

There are two modes. In loop mode, VL is taken from a biased immediate or from a scalar register, limited to the current MAXVL. In one-off mode, both MAXVL and VL are set to the biased immediate. A reserved pattern traps, and so does a register-sourced request that names x0. Writes to x0 are suppressed.

The unit also passes through instruction bits 63:60. Each of these is bit 6 of one seven-bit operand index. VL and MAXVL are held in registers. The writeback request, the trap flag and the source read index are combinational in the cycle the instruction is presented.

Top module: `vlen_prefix_ctl`

## Requirements
- R1: After reset, VL and MAXVL both read 1.
- R2: A control field of all zeros changes neither VL nor MAXVL, raises no writeback and no trap.
- R3: The field is reserved when bit 11 = 0, bits 5:0 = 0 and bits 10:6 are non-zero. A reserved field raises illegal_o in the cycle it is presented, raises no writeback, and leaves VL and MAXVL unchanged.
- R4: In loop mode (bit 11 = 0) with bit 0 = 0, the next VL is the smaller of (bits 5:1 + 1) and the current MAXVL. MAXVL is unchanged.
- R5: In loop mode with bit 0 = 1, rs_idx_o equals bits 5:1 and the next VL is the read value limited to the range 1 to MAXVL. A value of zero gives VL = 1, and a value above MAXVL gives MAXVL; the full 64-bit value is compared.
- R6: In loop mode with bit 0 = 1 and bits 5:1 = 0 (x0 as source), illegal_o is raised and no state changes.
- R7: In one-off mode (bit 11 = 1), MAXVL and VL both become bits 5:1 + 1.
- R8: Whenever VL is updated and bits 10:6 are non-zero, wb_en_o is high in the same cycle, wb_idx_o equals bits 10:6, and wb_data_o equals the new VL zero-extended. When bits 10:6 are zero, wb_en_o stays low.
- R9: ext_hi_o[3], [2], [1] and [0] carry instruction bits 63, 62, 61 and 60. These are bit 6 of rd, rs1, rs2 and rs3 respectively.
- R10: With valid_i low, no writeback or trap is raised and VL and MAXVL hold.
- R11: A VL or MAXVL update is visible on vl_o and maxvl_o one clock after the cycle in which valid_i is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| instr_i | input | 64 | Prefixed instruction word |
| valid_i | input | 1 | Instruction present this cycle |
| rs_data_i | input | XLEN | Value read from the scalar register at rs_idx_o |
| rs_idx_o | output | 5 | Scalar source register index (field bits 5:1) |
| vl_o | output | VL_W | Current vector length |
| maxvl_o | output | VL_W | Current vector length ceiling |
| wb_en_o | output | 1 | Scalar writeback enable |
| wb_idx_o | output | 5 | Scalar writeback index |
| wb_data_o | output | XLEN | Scalar writeback data (new VL) |
| illegal_o | output | 1 | Illegal-instruction trap |
| ext_hi_o | output | 4 | High index bits for rd, rs1, rs2, rs3 |

## Verification
The assertions assume the following about the inputs:

- rs_data_i is settled whenever valid_i is high and belongs to the index on rs_idx_o.
- valid_i is never X while out of reset.
- VL_W is wide enough to hold 32.

The bench drives every input on the falling edge and holds it for a full cycle. It keeps the 64-bit instruction's other bits at a fixed, non-zero pattern. It chooses register read values itself, so they are always defined, including values whose upper 32 bits are set.

// File: rtl/vlp_pkg.sv
package vlp_pkg;
  localparam int FIELD_LSB = 48;
  localparam int FIELD_W   = 12;
  localparam int IDX_W     = 5;

  typedef struct packed {
    logic             one_off;
    logic [IDX_W-1:0] dest;
    logic [IDX_W-1:0] imm;
    logic             from_reg;
  } vlp_field_t;

  typedef enum logic [2:0] {
    K_NOP      = 3'd0,
    K_LOOP_IMM = 3'd1,
    K_LOOP_REG = 3'd2,
    K_ONE_OFF  = 3'd3,
    K_RESERVED = 3'd4,
    K_BAD_SRC  = 3'd5
  } vlp_kind_e;
endpackage

// File: rtl/vlp_field_decode.sv
module vlp_field_decode
  import vlp_pkg::*;
(
  input  vlp_field_t      field_i,
  output vlp_kind_e       kind_o,
  output logic [IDX_W-1:0] dest_o,
  output logic [IDX_W-1:0] imm_o
);
  logic low_zero;
  assign low_zero = (field_i.imm == '0) && !field_i.from_reg;

  always_comb begin
    if (field_i.one_off)
      kind_o = K_ONE_OFF;
    else if (low_zero)
      kind_o = (field_i.dest == '0) ? K_NOP : K_RESERVED;
    else if (field_i.from_reg)
      kind_o = (field_i.imm == '0) ? K_BAD_SRC : K_LOOP_REG;
    else
      kind_o = K_LOOP_IMM;
  end

  assign dest_o = field_i.dest;
  assign imm_o  = field_i.imm;
endmodule

// File: rtl/vlp_len_compute.sv
module vlp_len_compute
  import vlp_pkg::*;
#(
  parameter int XLEN = 64,
  parameter int VL_W = 8
) (
  input  vlp_kind_e        kind_i,
  input  logic [IDX_W-1:0] imm_i,
  input  logic [XLEN-1:0]  rs_val_i,
  input  logic [VL_W-1:0]  cur_maxvl_i,
  output logic             update_o,
  output logic             trap_o,
  output logic [VL_W-1:0]  new_vl_o,
  output logic [VL_W-1:0]  new_maxvl_o
);
  function automatic logic [VL_W-1:0] biased(input logic [IDX_W-1:0] v);
    return VL_W'({1'b0, v}) + VL_W'(1);
  endfunction

  function automatic logic [VL_W-1:0] cap(input logic [VL_W-1:0] v,
                                          input logic [VL_W-1:0] lim);
    return (v > lim) ? lim : v;
  endfunction

  function automatic logic [VL_W-1:0] from_reg(input logic [XLEN-1:0] v,
                                               input logic [VL_W-1:0] lim);
    if (v == '0)                          return VL_W'(1);
    if (v > {{(XLEN-VL_W){1'b0}}, lim})   return lim;
    return v[VL_W-1:0];
  endfunction

  always_comb begin
    update_o    = 1'b0;
    trap_o      = 1'b0;
    new_vl_o    = '0;
    new_maxvl_o = cur_maxvl_i;
    unique case (kind_i)
      K_LOOP_IMM: begin
        update_o = 1'b1;
        new_vl_o = cap(biased(imm_i), cur_maxvl_i);
      end
      K_LOOP_REG: begin
        update_o = 1'b1;
        new_vl_o = from_reg(rs_val_i, cur_maxvl_i);
      end
      K_ONE_OFF: begin
        update_o    = 1'b1;
        new_vl_o    = biased(imm_i);
        new_maxvl_o = biased(imm_i);
      end
      K_RESERVED, K_BAD_SRC: trap_o = 1'b1;
      default: ;
    endcase
  end
endmodule

// File: rtl/vlp_len_regs.sv
module vlp_len_regs #(
  parameter int VL_W = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load_i,
  input  logic [VL_W-1:0] vl_d,
  input  logic [VL_W-1:0] maxvl_d,
  output logic [VL_W-1:0] vl_q,
  output logic [VL_W-1:0] maxvl_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vl_q    <= VL_W'(1);
      maxvl_q <= VL_W'(1);
    end else if (load_i) begin
      vl_q    <= vl_d;
      maxvl_q <= maxvl_d;
    end
  end
endmodule

// File: rtl/vlen_prefix_ctl.sv
module vlen_prefix_ctl
  import vlp_pkg::*;
#(
  parameter int XLEN = 64,
  parameter int VL_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [63:0]      instr_i,
  input  logic             valid_i,
  input  logic [XLEN-1:0]  rs_data_i,
  output logic [IDX_W-1:0] rs_idx_o,
  output logic [VL_W-1:0]  vl_o,
  output logic [VL_W-1:0]  maxvl_o,
  output logic             wb_en_o,
  output logic [IDX_W-1:0] wb_idx_o,
  output logic [XLEN-1:0]  wb_data_o,
  output logic             illegal_o,
  output logic [3:0]       ext_hi_o
);
  vlp_field_t       field;
  vlp_kind_e        kind;
  logic [IDX_W-1:0] dest, imm;
  logic             update, trap, commit;
  logic [VL_W-1:0]  nxt_vl, nxt_maxvl;
  logic [47:0]      unused_low;

  assign field      = vlp_field_t'(instr_i[FIELD_LSB +: FIELD_W]);
  assign unused_low = instr_i[47:0];

  vlp_field_decode u_dec (
    .field_i (field),
    .kind_o  (kind),
    .dest_o  (dest),
    .imm_o   (imm)
  );

  vlp_len_compute #(.XLEN(XLEN), .VL_W(VL_W)) u_calc (
    .kind_i      (kind),
    .imm_i       (imm),
    .rs_val_i    (rs_data_i),
    .cur_maxvl_i (maxvl_o),
    .update_o    (update),
    .trap_o      (trap),
    .new_vl_o    (nxt_vl),
    .new_maxvl_o (nxt_maxvl)
  );

  assign commit = valid_i && update;

  vlp_len_regs #(.VL_W(VL_W)) u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .load_i  (commit),
    .vl_d    (nxt_vl),
    .maxvl_d (nxt_maxvl),
    .vl_q    (vl_o),
    .maxvl_q (maxvl_o)
  );

  assign rs_idx_o  = imm;
  assign illegal_o = valid_i && trap;
  assign wb_en_o   = commit && (dest != '0);
  assign wb_idx_o  = dest;
  assign wb_data_o = {{(XLEN-VL_W){1'b0}}, nxt_vl};
  assign ext_hi_o  = instr_i[63:60];
endmodule

// File: rtl/vlp_ctl_checker.sv
module vlp_ctl_checker #(
  parameter int XLEN = 64,
  parameter int VL_W = 8
) (
  input logic            clk,
  input logic            rst_n,
  input logic            valid_i,
  input logic            illegal_o,
  input logic            wb_en_o,
  input logic [4:0]      wb_idx_o,
  input logic [XLEN-1:0] wb_data_o,
  input logic [VL_W-1:0] vl_o,
  input logic [VL_W-1:0] maxvl_o
);
  p_trap_no_wb_r3: assert property (@(posedge clk) disable iff (!rst_n)
    illegal_o |-> !wb_en_o);

  p_trap_holds_r6: assert property (@(posedge clk) disable iff (!rst_n)
    illegal_o |=> ($stable(vl_o) && $stable(maxvl_o)));

  p_wb_not_x0_r8: assert property (@(posedge clk) disable iff (!rst_n)
    wb_en_o |-> (wb_idx_o != 5'd0));

  p_wb_is_next_vl_r11: assert property (@(posedge clk) disable iff (!rst_n)
    wb_en_o |=> (vl_o == $past(wb_data_o[VL_W-1:0])));

  p_idle_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !valid_i |=> ($stable(vl_o) && $stable(maxvl_o)));

  p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !valid_i |-> (!wb_en_o && !illegal_o));

  p_vl_in_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (vl_o != '0) && (vl_o <= maxvl_o));
endmodule

bind vlen_prefix_ctl vlp_ctl_checker #(.XLEN(XLEN), .VL_W(VL_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .valid_i   (valid_i),
  .illegal_o (illegal_o),
  .wb_en_o   (wb_en_o),
  .wb_idx_o  (wb_idx_o),
  .wb_data_o (wb_data_o),
  .vl_o      (vl_o),
  .maxvl_o   (maxvl_o)
);

// File: tb/vlen_prefix_ctl_test.sv
module vlen_prefix_ctl_test;
  localparam int XLEN = 64;
  localparam int VL_W = 8;
  localparam int NV   = 13;
  localparam logic [47:0] LOW = 48'hA5C3_1234_5678;

  logic            clk = 1'b0;
  logic            rst_n;
  logic [63:0]     instr;
  logic            valid;
  logic [XLEN-1:0] rs_data;
  logic [4:0]      rs_idx, wb_idx;
  logic [VL_W-1:0] vl, maxvl;
  logic            wb_en, illegal;
  logic [XLEN-1:0] wb_data;
  logic [3:0]      ext_hi;
  int              runs = 0, fails = 0;
  bit              done = 0;

  always #4 clk = ~clk;

  vlen_prefix_ctl #(.XLEN(XLEN), .VL_W(VL_W)) uut (
    .clk(clk), .rst_n(rst_n), .instr_i(instr), .valid_i(valid),
    .rs_data_i(rs_data), .rs_idx_o(rs_idx), .vl_o(vl), .maxvl_o(maxvl),
    .wb_en_o(wb_en), .wb_idx_o(wb_idx), .wb_data_o(wb_data),
    .illegal_o(illegal), .ext_hi_o(ext_hi)
  );

  // {field[11:0], rs_data[63:0], exp_vl[7:0], exp_maxvl[7:0], exp_wb, exp_wbidx[4:0], exp_illegal}
  localparam logic [98:0] VEC [NV] = '{
    {12'b1_00011_01111_0, 64'd0,          8'd16, 8'd16, 1'b1, 5'd3,  1'b0}, // R7 one-off 16
    {12'b0_00000_00100_0, 64'd0,          8'd5,  8'd16, 1'b0, 5'd0,  1'b0}, // R4 imm 5
    {12'b0_00111_11111_0, 64'd0,          8'd16, 8'd16, 1'b1, 5'd7,  1'b0}, // R4 imm 32 capped
    {12'b0_00010_01001_1, 64'd10,         8'd10, 8'd16, 1'b1, 5'd2,  1'b0}, // R5 reg 10
    {12'b0_00000_01001_1, 64'd0,          8'd1,  8'd16, 1'b0, 5'd0,  1'b0}, // R5 reg 0 -> 1
    {12'b0_11111_00110_1, 64'd1000,       8'd16, 8'd16, 1'b1, 5'd31, 1'b0}, // R5 reg big
    {12'b0_00101_00000_0, 64'd0,          8'd16, 8'd16, 1'b0, 5'd0,  1'b1}, // R3 reserved
    {12'b0_00001_00000_1, 64'd4,          8'd16, 8'd16, 1'b0, 5'd0,  1'b1}, // R6 x0 source
    {12'b0_00000_00000_0, 64'd3,          8'd16, 8'd16, 1'b0, 5'd0,  1'b0}, // R2 nop
    {12'b1_00000_00000_0, 64'd0,          8'd1,  8'd1,  1'b0, 5'd0,  1'b0}, // R7 one-off 1
    {12'b0_00000_00011_0, 64'd0,          8'd1,  8'd1,  1'b0, 5'd0,  1'b0}, // R4 capped to 1
    {12'b1_00001_11111_0, 64'd0,          8'd32, 8'd32, 1'b1, 5'd1,  1'b0}, // R7 one-off 32
    {12'b0_01000_00010_1, 64'h1_0000_0003, 8'd32, 8'd32, 1'b1, 5'd8, 1'b0}  // R5 upper bits
  };

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    runs++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  initial begin
    #(8 * 20000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("[TB] %0d tests run, %0d failed", runs, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; valid = 1'b0; rs_data = '0; instr = {16'h0, LOW};
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    #1;
    chk("R1 vl reset", 64'(vl), 64'd1);
    chk("R1 maxvl reset", 64'(maxvl), 64'd1);

    for (int i = 0; i < NV; i++) begin
      logic [11:0] f;
      logic [7:0]  evl, emx;
      logic [4:0]  eidx;
      logic        ewb, eill;
      f = VEC[i][98:87];
      {evl, emx, ewb, eidx, eill} = VEC[i][22:0];
      @(negedge clk);
      instr = {4'b0000, f, LOW}; rs_data = VEC[i][86:23]; valid = 1'b1;
      #2;
      chk($sformatf("R3/R6 illegal v%0d", i), 64'(illegal), 64'(eill));
      chk($sformatf("R8 wb_en v%0d", i), 64'(wb_en), 64'(ewb));
      if (ewb) begin
        chk($sformatf("R8 wb_idx v%0d", i), 64'(wb_idx), 64'(eidx));
        chk($sformatf("R8 wb_data v%0d", i), wb_data, 64'(evl));
      end
      if (f[0] && !f[11]) chk($sformatf("R5 rs_idx v%0d", i), 64'(rs_idx), 64'(f[5:1]));
      @(posedge clk); #1;
      chk($sformatf("R11 vl v%0d", i), 64'(vl), 64'(evl));
      chk($sformatf("R11 maxvl v%0d", i), 64'(maxvl), 64'(emx));
    end

    // R10: valid low with a one-off field present
    @(negedge clk);
    valid = 1'b0; instr = {4'b0000, 12'b1_00100_00010_0, LOW};
    #2;
    chk("R10 no wb", 64'(wb_en), 64'd0);
    chk("R10 no trap", 64'(illegal), 64'd0);
    @(posedge clk); #1;
    chk("R10 vl hold", 64'(vl), 64'd32);
    chk("R10 maxvl hold", 64'(maxvl), 64'd32);

    // R9: high index bits
    @(negedge clk);
    instr = {4'b1010, 12'h0, LOW}; #2;
    chk("R9 ext 1010", 64'(ext_hi), 64'hA);
    instr = {4'b0101, 12'h0, LOW}; #2;
    chk("R9 ext 0101", 64'(ext_hi), 64'h5);

    // R1: reset mid-run
    @(negedge clk); rst_n = 1'b0;
    @(posedge clk); #1;
    chk("R1 vl re-reset", 64'(vl), 64'd1);
    chk("R1 maxvl re-reset", 64'(maxvl), 64'd1);
    @(negedge clk); rst_n = 1'b1;

    done = 1;
    $display("[TB] %0d tests run, %0d failed", runs, fails);
    $finish;
  end
endmodule